// File: doc/BRIEF.md
# Coprocessor Shared RAM Host Window

This block lets a host processor reach the private byte-wide RAM of an attached coprocessor through four byte registers. The host first places a 16-bit RAM pointer by writing its low and high bytes separately. It then moves bytes through a data register. When auto-stepping is enabled, each data access advances the pointer by one. This lets the host upload, download or compare long regions without reloading the address.

The same control register that enables auto-stepping also runs or halts the coprocessor and selects its bypass mode. It can also ring a one-cycle doorbell toward the coprocessor. The coprocessor reaches the RAM through a second, plain synchronous port. This port is how it leaves values for the host, for example a check-in byte of 0xFF that the host later clears to 0.

The RAM is a synchronous memory of 2**RAM_AW bytes that can be inferred as block RAM. The pointer is always 16 bits wide. When the RAM is smaller than 64 KiB, pointer values above its size alias onto its low address bits.

Top module: `shram_host_port`

## Requirements
- R1: In a cycle with `rst` high, the pointer is set to 0 and the run, auto-step, bypass and doorbell state is cleared. `cp_run`, `cp_bypass` and `cp_doorbell` read 0 in the following cycle.
- R2: Writing offset 0 replaces bits 7:0 of the pointer, and writing offset 1 replaces bits 15:8; the other half keeps its value. Reading offset 0 or 1 returns that half, and the value appears on `host_rdata` in the cycle after the read strobe.
- R3: A write to offset 2 stores `host_wdata` into RAM at the pointer. A read of offset 2 returns the RAM byte at the pointer, and the byte appears on `host_rdata` in the cycle after the strobe.
- R4: When the auto-step bit is 1, every data access (read or write of offset 2) advances the pointer by one, and the access itself uses the old pointer. When the auto-step bit is 0, a data access leaves the pointer unchanged.
- R5: Auto-stepping from pointer 0xFFFF gives 0x0000.
- R6: The control register sits at offset 3, with bit 0 for bypass, bit 1 for auto-step, bit 2 for run and bit 3 for doorbell. Bits 7:4 are ignored on write and read back as 0, so raw values 0x87 and 0x00 are both accepted. `cp_run` and `cp_bypass` take the written bits in the next cycle.
- R7: A control write with bit 3 set drives `cp_doorbell` high for exactly the next cycle, and it falls again unless another such write follows. Bit 3 of a later control read returns 0.
- R8: The coprocessor port writes `cp_wdata` at `cp_addr` when `cp_we` is high. It returns the byte at `cp_addr` on `cp_rdata` in the next cycle. A byte the coprocessor writes is visible to the host, and a byte the host writes is visible to the coprocessor. If both ports write the same address in the same cycle, the coprocessor's byte is kept.
- R9: With `host_sel` low, the host strobes have no effect. If `host_wr` and `host_rd` are both high, only the write is performed.
- R10: The RAM is indexed by the low RAM_AW bits of the pointer, so pointers that differ only above those bits reach the same byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Host register access enable |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_off | input | 2 | Register offset (0 ptr low, 1 ptr high, 2 data, 3 control) |
| host_wdata | input | DATA_W | Host write byte |
| host_rdata | output | DATA_W | Host read byte, valid the cycle after a read |
| cp_we | input | 1 | Coprocessor RAM write enable |
| cp_addr | input | RAM_AW | Coprocessor RAM address |
| cp_wdata | input | DATA_W | Coprocessor write byte |
| cp_rdata | output | DATA_W | Coprocessor read byte, one cycle latency |
| cp_run | output | 1 | Coprocessor run enable |
| cp_bypass | output | 1 | Bypass mode select |
| cp_doorbell | output | 1 | One-cycle doorbell pulse toward the coprocessor |

## Verification
The bench builds the block with RAM_AW = 8, which gives a 256-byte RAM. At this size a pointer such as 0x1234 lands on the same byte as 0x0034, so the aliasing rule can be checked within a few accesses. The 16-bit pointer itself is still exercised across its wrap from 0xFFFF to 0x0000. With the data width left at 8, the raw control values 0x87 and 0x00 can be applied exactly as a host would write them.

// File: rtl/shram_pkg.sv
package shram_pkg;
  // Host register offsets
  localparam logic [1:0] OFF_PTR_LO = 2'd0;
  localparam logic [1:0] OFF_PTR_HI = 2'd1;
  localparam logic [1:0] OFF_DATA   = 2'd2;
  localparam logic [1:0] OFF_CTRL   = 2'd3;

  // Control register bit positions
  localparam int CB_BYPASS = 0;
  localparam int CB_STEP   = 1;
  localparam int CB_RUN    = 2;
  localparam int CB_BELL   = 3;

  typedef struct packed {
    logic run;
    logic step;
    logic bypass;
  } ctrl_t;
endpackage

// File: rtl/shram_mem.sv
module shram_mem #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  // host side
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wd,
  output logic [DW-1:0] a_q,
  // coprocessor side
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wd,
  output logic [DW-1:0] b_q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Read-before-write on both ports; coprocessor write is applied last.
  always_ff @(posedge clk) begin
    if (a_en && a_we) mem[a_addr] <= a_wd;
    if (b_we)         mem[b_addr] <= b_wd;
  end

  always_ff @(posedge clk) begin
    if (a_en) a_q <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_q <= mem[b_addr];
  end
endmodule

// File: rtl/shram_regs.sv
module shram_regs
  import shram_pkg::*;
#(
  parameter int DW = 8,
  parameter int PW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic          wr_ctrl,
  input  logic          data_acc,
  input  logic [DW-1:0] wdata,
  output logic [PW-1:0] ptr,
  output ctrl_t         ctrl,
  output logic          bell
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (wr_lo) begin
      ptr[DW-1:0] <= wdata;
    end else if (wr_hi) begin
      ptr[PW-1:DW] <= wdata;
    end else if (data_acc && ctrl.step) begin
      ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      bell <= 1'b0;
    end else begin
      bell <= wr_ctrl && wdata[CB_BELL];
      if (wr_ctrl) begin
        ctrl.run    <= wdata[CB_RUN];
        ctrl.step   <= wdata[CB_STEP];
        ctrl.bypass <= wdata[CB_BYPASS];
      end
    end
  end
endmodule

// File: rtl/shram_host_port.sv
module shram_host_port
  import shram_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RAM_AW = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [1:0]        host_off,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              cp_we,
  input  logic [RAM_AW-1:0] cp_addr,
  input  logic [DATA_W-1:0] cp_wdata,
  output logic [DATA_W-1:0] cp_rdata,
  output logic              cp_run,
  output logic              cp_bypass,
  output logic              cp_doorbell
);
  localparam int PTR_W = 2 * DATA_W;

  logic              acc_wr, acc_rd, data_acc;
  logic [PTR_W-1:0]  ptr_q;
  ctrl_t             ctrl_q;
  logic              bell_q;
  logic [DATA_W-1:0] ram_q, reg_q, reg_d;
  logic [1:0]        rd_off_q;

  assign acc_wr   = host_sel && host_wr;
  assign acc_rd   = host_sel && host_rd && !host_wr;
  assign data_acc = (acc_wr || acc_rd) && (host_off == OFF_DATA);

  shram_regs #(.DW(DATA_W), .PW(PTR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_lo    (acc_wr && host_off == OFF_PTR_LO),
    .wr_hi    (acc_wr && host_off == OFF_PTR_HI),
    .wr_ctrl  (acc_wr && host_off == OFF_CTRL),
    .data_acc (data_acc),
    .wdata    (host_wdata),
    .ptr      (ptr_q),
    .ctrl     (ctrl_q),
    .bell     (bell_q)
  );

  shram_mem #(.AW(RAM_AW), .DW(DATA_W)) u_mem (
    .clk    (clk),
    .a_en   (data_acc),
    .a_we   (acc_wr),
    .a_addr (ptr_q[RAM_AW-1:0]),
    .a_wd   (host_wdata),
    .a_q    (ram_q),
    .b_we   (cp_we),
    .b_addr (cp_addr),
    .b_wd   (cp_wdata),
    .b_q    (cp_rdata)
  );

  always_comb begin
    reg_d = '0;
    case (host_off)
      OFF_PTR_LO: reg_d = ptr_q[DATA_W-1:0];
      OFF_PTR_HI: reg_d = ptr_q[PTR_W-1:DATA_W];
      OFF_CTRL: begin
        reg_d[CB_BYPASS] = ctrl_q.bypass;
        reg_d[CB_STEP]   = ctrl_q.step;
        reg_d[CB_RUN]    = ctrl_q.run;
        reg_d[CB_BELL]   = bell_q;
      end
      default: reg_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q    <= '0;
      rd_off_q <= OFF_PTR_LO;
    end else if (acc_rd) begin
      reg_q    <= reg_d;
      rd_off_q <= host_off;
    end
  end

  assign host_rdata  = (rd_off_q == OFF_DATA) ? ram_q : reg_q;
  assign cp_run      = ctrl_q.run;
  assign cp_bypass   = ctrl_q.bypass;
  assign cp_doorbell = bell_q;
endmodule

// File: rtl/shram_host_port_chk.sv
module shram_host_port_chk #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              host_sel,
  input logic              host_wr,
  input logic              host_rd,
  input logic [1:0]        host_off,
  input logic [DATA_W-1:0] host_wdata,
  input logic [PTR_W-1:0]  ptr,
  input logic              step,
  input logic              cp_run,
  input logic              cp_doorbell
);
  logic data_acc, ctrl_wr, lo_wr;
  assign data_acc = host_sel && (host_wr || host_rd) && host_off == 2'd2;
  assign ctrl_wr  = host_sel && host_wr && host_off == 2'd3;
  assign lo_wr    = host_sel && host_wr && host_off == 2'd0;

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!cp_run && !cp_doorbell && ptr == '0));

  // R2
  lo_load_chk: assert property (@(posedge clk) disable iff (rst)
    lo_wr |=> ptr[DATA_W-1:0] == $past(host_wdata));

  // R4
  step_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (data_acc && step) |=> ptr == $past(ptr) + 1'b1);

  // R4
  step_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (data_acc && !step) |=> $stable(ptr));

  // R6
  run_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> cp_run == $past(host_wdata[2]));

  // R7
  bell_src_chk: assert property (@(posedge clk) disable iff (rst)
    cp_doorbell |-> $past(ctrl_wr && host_wdata[3]));
endmodule

bind shram_host_port shram_host_port_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .host_sel    (host_sel),
  .host_wr     (host_wr),
  .host_rd     (host_rd),
  .host_off    (host_off),
  .host_wdata  (host_wdata),
  .ptr         (ptr_q),
  .step        (ctrl_q.step),
  .cp_run      (cp_run),
  .cp_doorbell (cp_doorbell)
);

// File: tb/shram_host_port_bench.sv
module shram_host_port_bench;
  localparam int DW = 8;
  localparam int AW = 8;
  localparam int RAM_SZ = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_sel = 0, host_wr = 0, host_rd = 0;
  logic [1:0]    host_off = 0;
  logic [DW-1:0] host_wdata = 0;
  logic [DW-1:0] host_rdata;
  logic          cp_we = 0;
  logic [AW-1:0] cp_addr = 0;
  logic [DW-1:0] cp_wdata = 0;
  logic [DW-1:0] cp_rdata;
  logic          cp_run, cp_bypass, cp_doorbell;

  always #10 clk = ~clk;

  shram_host_port #(.DATA_W(DW), .RAM_AW(AW)) u_shram_host_port (
    .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
    .host_off(host_off), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cp_we(cp_we), .cp_addr(cp_addr), .cp_wdata(cp_wdata), .cp_rdata(cp_rdata),
    .cp_run(cp_run), .cp_bypass(cp_bypass), .cp_doorbell(cp_doorbell)
  );

  // Behavioural reference model
  int  m_ptr, m_run, m_step, m_byp, m_bell;
  int  m_hexp, m_cexp;
  bit  m_hval, m_cval;
  byte m_mem [int];
  int  n_run = 0, n_fail = 0;

  always @(posedge clk) begin
    int idx;
    if (rst) begin
      m_ptr = 0; m_run = 0; m_step = 0; m_byp = 0; m_bell = 0;
      m_hval = 0; m_cval = 0;
    end else begin
      m_hval = 0;
      idx = m_ptr % RAM_SZ;
      m_cval = m_mem.exists(int'(cp_addr));
      if (m_cval) m_cexp = int'(m_mem[int'(cp_addr)]) & 8'hFF;
      if (host_sel && host_wr) begin
        case (host_off)
          2'd0: m_ptr = (m_ptr & 16'hFF00) | int'(host_wdata);
          2'd1: m_ptr = (int'(host_wdata) << 8) | (m_ptr & 16'h00FF);
          2'd2: begin
            m_mem[idx] = byte'(host_wdata);
            if (m_step != 0) m_ptr = (m_ptr + 1) & 16'hFFFF;
          end
          default: begin
            m_byp = host_wdata[0]; m_step = host_wdata[1]; m_run = host_wdata[2];
          end
        endcase
        m_bell = (host_off == 2'd3) ? int'(host_wdata[3]) : 0;
      end else begin
        if (host_sel && host_rd) begin
          m_hval = 1;
          case (host_off)
            2'd0: m_hexp = m_ptr & 8'hFF;
            2'd1: m_hexp = m_ptr >> 8;
            2'd2: begin
              m_hval = m_mem.exists(idx);
              if (m_hval) m_hexp = int'(m_mem[idx]) & 8'hFF;
              if (m_step != 0) m_ptr = (m_ptr + 1) & 16'hFFFF;
            end
            default: m_hexp = (m_bell << 3) | (m_run << 2) | (m_step << 1) | m_byp;
          endcase
        end
        m_bell = 0;
      end
      if (cp_we) m_mem[int'(cp_addr)] = byte'(cp_wdata);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Compared every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R6 cp_run", int'(cp_run), m_run);
      chk("R6 cp_bypass", int'(cp_bypass), m_byp);
      chk("R7 cp_doorbell", int'(cp_doorbell), m_bell);
      if (m_hval) chk("R3/R2 host_rdata", int'(host_rdata), m_hexp);
      if (m_cval) chk("R8 cp_rdata", int'(cp_rdata), m_cexp);
    end
  end

  task automatic hw(input logic [1:0] off, input logic [7:0] d);
    @(negedge clk);
    host_sel = 1; host_wr = 1; host_rd = 0; host_off = off; host_wdata = d;
    @(negedge clk);
    host_sel = 0; host_wr = 0;
  endtask

  task automatic hr(input logic [1:0] off);
    @(negedge clk);
    host_sel = 1; host_wr = 0; host_rd = 1; host_off = off;
    @(negedge clk);
    host_sel = 0; host_rd = 0;
  endtask

  task automatic cw(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cp_we = 1; cp_addr = a; cp_wdata = d;
    @(negedge clk);
    cp_we = 0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state read back
    hr(2'd0); hr(2'd1); hr(2'd3);
    @(negedge clk);
    chk("R1 ctrl after reset", int'(host_rdata), 0);

    // R2: pointer halves loaded separately
    hw(2'd0, 8'h10); hw(2'd1, 8'h00); hr(2'd0); hr(2'd1);
    hw(2'd1, 8'hAB); hr(2'd0); hr(2'd1);

    // R4/R3: block upload then download with auto-step (start = run+step)
    hw(2'd3, 8'h06);
    hw(2'd0, 8'h10); hw(2'd1, 8'h00);
    for (int i = 0; i < 16; i++) hw(2'd2, 8'(8'h30 + i * 7));
    hr(2'd0);
    hw(2'd0, 8'h10);
    for (int i = 0; i < 16; i++) hr(2'd2);
    hr(2'd0);

    // R4: auto-step off keeps the pointer
    hw(2'd3, 8'h04);
    hw(2'd0, 8'h40); hw(2'd2, 8'h11); hw(2'd2, 8'h22); hr(2'd2); hr(2'd0);

    // R5: wrap 0xFFFF -> 0x0000
    hw(2'd3, 8'h02);
    hw(2'd0, 8'hFF); hw(2'd1, 8'hFF); hw(2'd2, 8'h5A); hr(2'd0); hr(2'd1);

    // R6: raw 0x87 and 0x00
    hw(2'd3, 8'h87); hr(2'd3);
    @(negedge clk);
    chk("R6 ctrl 0x87 readback", int'(host_rdata), 8'h07);
    hw(2'd3, 8'h00); hr(2'd3);

    // R7: doorbell pulse, self-clearing
    hw(2'd3, 8'h0E); hr(2'd3); hr(2'd3);
    chk("R7 doorbell low later", int'(cp_doorbell), 0);

    // R8: liveness byte from coprocessor, cleared by host
    cw(8'h20, 8'hFF);
    hw(2'd3, 8'h02); hw(2'd0, 8'h20); hw(2'd1, 8'h00); hr(2'd2);
    hw(2'd0, 8'h20); hw(2'd2, 8'h00);
    cw(8'h21, 8'h00);
    @(negedge clk); cp_addr = 8'h20;
    @(negedge clk); @(negedge clk);
    chk("R8 liveness cleared", int'(cp_rdata), 0);
    // R8: same-address collision, coprocessor wins
    hw(2'd0, 8'h60);
    @(negedge clk);
    host_sel = 1; host_wr = 1; host_off = 2'd2; host_wdata = 8'h12;
    cp_we = 1; cp_addr = 8'h60; cp_wdata = 8'h34;
    @(negedge clk);
    host_sel = 0; host_wr = 0; cp_we = 0;
    hw(2'd0, 8'h60); hr(2'd2);

    // R10: aliasing above the RAM size
    hw(2'd0, 8'h34); hw(2'd1, 8'h12); hw(2'd2, 8'hC3);
    hw(2'd0, 8'h34); hw(2'd1, 8'h00); hr(2'd2);

    // R9: sel low ignored; write wins over read
    @(negedge clk);
    host_sel = 0; host_wr = 1; host_off = 2'd0; host_wdata = 8'h99;
    @(negedge clk);
    host_wr = 0;
    hr(2'd0);
    @(negedge clk);
    chk("R9 sel low ignored", int'(host_rdata), 8'h35);
    @(negedge clk);
    host_sel = 1; host_wr = 1; host_rd = 1; host_off = 2'd0; host_wdata = 8'h77;
    @(negedge clk);
    host_sel = 0; host_wr = 0; host_rd = 0;
    hr(2'd0);
    @(negedge clk);
    chk("R9 write wins", int'(host_rdata), 8'h77);

    // R1: reset mid-run
    hw(2'd3, 8'h07);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R1 run cleared", int'(cp_run), 0);
    hr(2'd0);
    @(negedge clk);
    chk("R1 ptr cleared", int'(host_rdata), 0);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule